// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a 32-bit register file and a byte-addressed data memory port. It reshapes data for loads and stores; it does not generate addresses. For a load it receives the aligned memory word, the low address bits, an access kind, a signed/unsigned flag and a byte-order flag. It extracts the addressed byte, halfword or word and extends it to register width. For the two partial operations used on unaligned words, it merges the selected bytes into the old destination register value instead. The load result, a write enable and a misalignment flag are registered and appear one cycle after the memory data is presented.

For a store, the block moves the register data into the correct byte lanes of the memory word and produces the matching byte enables. This path is combinational. The byte order can be switched from one access to the next. When a halfword or word is not aligned to its size, the block only raises a flag and suppresses the write. A surrounding pipeline decides what to do with that flag.

Memory word lane i (bits 8i+7..8i) always holds the byte at address offset i. The access kind codes are 0 byte, 1 halfword, 2 word, 3 left partial, 4 right partial. Any other code writes nothing.

Top module: `lsu_align`

## Requirements
- R1: A byte load (kind 0) at offset a returns lane a of the memory word. It is sign-extended when `ld_signed` is 1 and zero-extended when it is 0.
- R2: A halfword load (kind 1) at even offset a uses the bytes at offsets a and a+1. In big-endian order, offset a is the high byte. In little-endian order, offset a+1 is the high byte. The halfword is then sign- or zero-extended as in R1.
- R3: A word load (kind 2) at offset 0 returns the memory word unchanged in little-endian order and byte-reversed in big-endian order.
- R4: A left partial load (kind 3) at offset a in big-endian order writes the bytes at offsets a..3 into register bytes 3 downward. In little-endian order it writes the bytes at offsets a..0 into register bytes 3 downward. All other register bytes keep `ld_old`.
- R5: A right partial load (kind 4) at offset a in big-endian order writes the bytes at offsets a..0 into register bytes 0 upward. In little-endian order it writes the bytes at offsets a..3 into register bytes 0 upward. All other register bytes keep `ld_old`.
- R6: A halfword load at an odd offset, or a word load at a nonzero offset, raises `ld_misalign`. It leaves `ld_wen` low and `ld_data` unchanged.
- R7: Load outputs change on the clock edge at which `ld_valid` is sampled. In a cycle after `ld_valid` was low, `ld_wen` and `ld_misalign` are low and `ld_data` holds its value. Reset clears all three.
- R8: A byte store puts the data byte in all four lanes and sets only enable bit a. An aligned halfword store puts the halfword, ordered as in R2, in both halves and sets enable bits a and a+1.
- R9: A word store at offset 0 sets all four enables. The data lanes are ordered as in R3.
- R10: A left partial store enables exactly the offsets that a left partial load at the same offset and byte order reads, and writes the matching register bytes there. A right partial store does the same in mirror. Neither partial store ever flags misalignment.
- R11: A misaligned halfword or word store raises `st_misalign` with all enables low. With `st_valid` low, all enables and the flag are low.
- R12: A right-then-left pair (little-endian) or a left-then-right pair (big-endian) of partial loads, or the matching pair of partial stores, transfers a whole unaligned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| big_end | input | 1 | 1 selects big-endian order for both paths |
| ld_valid | input | 1 | Memory load data valid this cycle |
| ld_kind | input | 3 | Load access kind code |
| ld_ofs | input | 2 | Low address bits of the load |
| ld_signed | input | 1 | 1 sign-extends byte and halfword loads |
| ld_mem | input | 32 | Aligned memory word |
| ld_old | input | 32 | Current destination register value |
| ld_data | output | 32 | Registered load result |
| ld_wen | output | 1 | Registered register write enable |
| ld_misalign | output | 1 | Registered load misalignment flag |
| st_valid | input | 1 | Store request this cycle |
| st_kind | input | 3 | Store access kind code |
| st_ofs | input | 2 | Low address bits of the store |
| st_src | input | 32 | Register data to store |
| st_wdata | output | 32 | Lane-placed store data |
| st_be | output | 4 | Byte enables by address offset |
| st_misalign | output | 1 | Store misalignment flag |

## Verification
The assertions check the control relations on every cycle:
- the one-cycle load timing and the quiet outputs after an idle cycle;
- the held result with the write enable low on a misaligned load;
- empty enables on misaligned or idle stores;
- a single lane for byte stores and all four lanes for word stores;
- partial stores that never flag and always enable at least one lane.

The byte placement itself can only be shown by the bench's scenarios. These cover the extension of each field, the lane choice under each byte order, the merge with the old register value, and whether a left/right pair really assembles one unaligned word in registers or in memory.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [2:0] {
      ACC_BYTE  = 3'd0,
      ACC_HALF  = 3'd1,
      ACC_WORD  = 3'd2,
      ACC_LEFT  = 3'd3,
      ACC_RIGHT = 3'd4
   } acc_kind_e;

endpackage

// File: rtl/lsu_lane_order.sv
module lsu_lane_order #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      swap,
   input  logic [LANES*LANE_W-1:0]   din,
   output logic [LANES*LANE_W-1:0]   dout
);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign dout[i*LANE_W +: LANE_W] = swap ? din[(LANES-1-i)*LANE_W +: LANE_W]
                                                : din[i*LANE_W +: LANE_W];
      end
   endgenerate

endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
   import lsu_align_pkg::*;
#(
   parameter int NBYTES = 4
) (
   input  logic [2:0]                 kind,
   input  logic [$clog2(NBYTES)-1:0]  ofs,
   input  logic                       sgn,
   input  logic                       big_end,
   input  logic [8*NBYTES-1:0]        mem,
   input  logic [8*NBYTES-1:0]        old,
   output logic [8*NBYTES-1:0]        value,
   output logic                       misal,
   output logic                       write_ok
);

   localparam int W  = 8 * NBYTES;
   localparam int AW = $clog2(NBYTES);

   logic [W-1:0]  wv;        // memory word in register significance order
   logic [W-1:0]  lft, rgt;
   logic [15:0]   low16;
   logic [15:0]   half;
   logic [AW-1:0] k, kc;

   lsu_lane_order #(.LANES(NBYTES), .LANE_W(8)) u_order (
      .swap (big_end),
      .din  (mem),
      .dout (wv)
   );

   always_comb begin
      k     = big_end ? ofs : ~ofs;
      kc    = ~k;
      low16 = 16'(mem >> {ofs, 3'b000});
      half  = big_end ? {low16[7:0], low16[15:8]} : low16;
      lft   = wv << {k, 3'b000};
      rgt   = wv >> {kc, 3'b000};
   end

   always_comb begin
      value    = old;
      misal    = 1'b0;
      write_ok = 1'b0;
      case (kind)
         ACC_BYTE: begin
            value    = {{(W-8){sgn & low16[7]}}, low16[7:0]};
            write_ok = 1'b1;
         end
         ACC_HALF: begin
            if (ofs[0]) begin
               misal = 1'b1;
            end else begin
               value    = {{(W-16){sgn & half[15]}}, half};
               write_ok = 1'b1;
            end
         end
         ACC_WORD: begin
            if (ofs != '0) begin
               misal = 1'b1;
            end else begin
               value    = wv;
               write_ok = 1'b1;
            end
         end
         ACC_LEFT: begin
            for (int i = 0; i < NBYTES; i++)
               if (i >= int'(k)) value[8*i +: 8] = lft[8*i +: 8];
            write_ok = 1'b1;
         end
         ACC_RIGHT: begin
            for (int i = 0; i < NBYTES; i++)
               if (i <= int'(k)) value[8*i +: 8] = rgt[8*i +: 8];
            write_ok = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
   import lsu_align_pkg::*;
#(
   parameter int NBYTES = 4
) (
   input  logic                       valid,
   input  logic [2:0]                 kind,
   input  logic [$clog2(NBYTES)-1:0]  ofs,
   input  logic                       big_end,
   input  logic [8*NBYTES-1:0]        data,
   output logic [8*NBYTES-1:0]        wdata,
   output logic [NBYTES-1:0]          be,
   output logic                       misal
);

   localparam int W  = 8 * NBYTES;
   localparam int AW = $clog2(NBYTES);

   logic [W-1:0]      vdat, mdat;   // value order and address order
   logic [NBYTES-1:0] vmask, mmask;
   logic [AW-1:0]     k, kc;
   logic [15:0]       hv;

   always_comb begin
      k     = big_end ? ofs : ~ofs;
      kc    = ~k;
      vdat  = data;
      vmask = '0;
      case (kind)
         ACC_WORD:  vmask = (ofs == '0) ? '1 : '0;
         ACC_LEFT: begin
            vdat = data >> {k, 3'b000};
            for (int i = 0; i < NBYTES; i++) vmask[i] = (i <= int'(kc));
         end
         ACC_RIGHT: begin
            vdat = data << {kc, 3'b000};
            for (int i = 0; i < NBYTES; i++) vmask[i] = (i >= int'(kc));
         end
         default: ;
      endcase
   end

   lsu_lane_order #(.LANES(NBYTES), .LANE_W(8)) u_dat_order (
      .swap (big_end),
      .din  (vdat),
      .dout (mdat)
   );

   lsu_lane_order #(.LANES(NBYTES), .LANE_W(1)) u_msk_order (
      .swap (big_end),
      .din  (vmask),
      .dout (mmask)
   );

   always_comb begin
      hv    = big_end ? {data[7:0], data[15:8]} : data[15:0];
      wdata = '0;
      be    = '0;
      misal = 1'b0;
      if (valid) begin
         case (kind)
            ACC_BYTE: begin
               wdata = {NBYTES{data[7:0]}};
               be    = NBYTES'(1) << ofs;
            end
            ACC_HALF: begin
               wdata = {(NBYTES/2){hv}};
               if (ofs[0]) misal = 1'b1;
               else        be    = NBYTES'(3) << ofs;
            end
            ACC_WORD: begin
               wdata = mdat;
               be    = mmask;
               misal = (ofs != '0);
            end
            ACC_LEFT, ACC_RIGHT: begin
               wdata = mdat;
               be    = mmask;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
   import lsu_align_pkg::*;
#(
   parameter int NBYTES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       big_end,
   input  logic                       ld_valid,
   input  logic [2:0]                 ld_kind,
   input  logic [$clog2(NBYTES)-1:0]  ld_ofs,
   input  logic                       ld_signed,
   input  logic [8*NBYTES-1:0]        ld_mem,
   input  logic [8*NBYTES-1:0]        ld_old,
   output logic [8*NBYTES-1:0]        ld_data,
   output logic                       ld_wen,
   output logic                       ld_misalign,
   input  logic                       st_valid,
   input  logic [2:0]                 st_kind,
   input  logic [$clog2(NBYTES)-1:0]  st_ofs,
   input  logic [8*NBYTES-1:0]        st_src,
   output logic [8*NBYTES-1:0]        st_wdata,
   output logic [NBYTES-1:0]          st_be,
   output logic                       st_misalign
);

   localparam int W = 8 * NBYTES;

   generate
      if (NBYTES < 2 || (NBYTES & (NBYTES - 1)) != 0) begin : g_bad_width
         $error("lsu_align: NBYTES must be a power of two and at least 2");
      end
   endgenerate

   logic [W-1:0] lp_value;
   logic         lp_mis, lp_ok;

   lsu_load_path #(.NBYTES(NBYTES)) u_load (
      .kind     (ld_kind),
      .ofs      (ld_ofs),
      .sgn      (ld_signed),
      .big_end  (big_end),
      .mem      (ld_mem),
      .old      (ld_old),
      .value    (lp_value),
      .misal    (lp_mis),
      .write_ok (lp_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_data     <= '0;
         ld_wen      <= 1'b0;
         ld_misalign <= 1'b0;
      end else begin
         ld_wen      <= ld_valid & lp_ok;
         ld_misalign <= ld_valid & lp_mis;
         if (ld_valid & lp_ok) ld_data <= lp_value;
      end
   end

   lsu_store_path #(.NBYTES(NBYTES)) u_store (
      .valid   (st_valid),
      .kind    (st_kind),
      .ofs     (st_ofs),
      .big_end (big_end),
      .data    (st_src),
      .wdata   (st_wdata),
      .be      (st_be),
      .misal   (st_misalign)
   );

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_kind == ACC_WORD && ld_ofs == '0) |=> ld_wen); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> (!ld_wen && !ld_misalign && $stable(ld_data))); // R7
   AST_MIS_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ld_misalign |-> (!ld_wen && $stable(ld_data))); // R6
   AST_HALF_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_kind == ACC_HALF && ld_ofs[0]) |=> ld_misalign); // R6
   AST_PARTIAL_NO_MIS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && (st_kind == ACC_LEFT || st_kind == ACC_RIGHT)) |-> (!st_misalign && st_be != '0)); // R10
   AST_MIS_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      st_misalign |-> (st_be == '0)); // R11
   AST_STORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> (st_be == '0 && !st_misalign)); // R11
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_kind == ACC_BYTE) |-> ($countones(st_be) == 1)); // R8
   AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_kind == ACC_WORD && st_ofs == '0) |-> (&st_be)); // R9

endmodule

// File: tb/tb_lsu_align.sv
module tb_lsu_align;

   localparam int CLK_PERIOD = 10;

   logic        clk, rst_n, big_end;
   logic        ld_valid, ld_signed;
   logic [2:0]  ld_kind;
   logic [1:0]  ld_ofs;
   logic [31:0] ld_mem, ld_old, ld_data;
   logic        ld_wen, ld_misalign;
   logic        st_valid;
   logic [2:0]  st_kind;
   logic [1:0]  st_ofs;
   logic [31:0] st_src, st_wdata;
   logic [3:0]  st_be;
   logic        st_misalign;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   lsu_align dut (
      .clk(clk), .rst_n(rst_n), .big_end(big_end),
      .ld_valid(ld_valid), .ld_kind(ld_kind), .ld_ofs(ld_ofs), .ld_signed(ld_signed),
      .ld_mem(ld_mem), .ld_old(ld_old), .ld_data(ld_data), .ld_wen(ld_wen),
      .ld_misalign(ld_misalign),
      .st_valid(st_valid), .st_kind(st_kind), .st_ofs(st_ofs), .st_src(st_src),
      .st_wdata(st_wdata), .st_be(st_be), .st_misalign(st_misalign)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // scoreboard queues for the load path
   logic [33:0] exp_q[$];   // {wen, misalign, data}
   string       tag_q[$];
   logic [31:0] exp_hold;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void ld_model(input logic [2:0] kind, input int a, input logic sgn,
                                    input logic bo, input logic [31:0] mem,
                                    input logic [31:0] old, output logic ok,
                                    output logic mis, output logic [31:0] res);
      logic [7:0]  mb[4];
      logic [15:0] h;
      for (int i = 0; i < 4; i++) mb[i] = mem[8*i +: 8];
      ok = 1'b0; mis = 1'b0; res = old;
      case (kind)
         3'd0: begin ok = 1'b1; res = {{24{sgn & mb[a][7]}}, mb[a]}; end
         3'd1: if (a % 2 == 1) mis = 1'b1;
               else begin
                  h   = bo ? {mb[a], mb[a+1]} : {mb[a+1], mb[a]};
                  ok  = 1'b1;
                  res = {{16{sgn & h[15]}}, h};
               end
         3'd2: if (a != 0) mis = 1'b1;
               else begin
                  ok  = 1'b1;
                  res = bo ? {mb[0], mb[1], mb[2], mb[3]} : {mb[3], mb[2], mb[1], mb[0]};
               end
         3'd3: begin
            ok = 1'b1;
            if (bo) for (int j = 0; j <= 3 - a; j++) res[8*(3-j) +: 8] = mb[a+j];
            else    for (int j = 0; j <= a; j++)     res[8*(3-j) +: 8] = mb[a-j];
         end
         3'd4: begin
            ok = 1'b1;
            if (bo) for (int i = 0; i <= a; i++)     res[8*i +: 8] = mb[a-i];
            else    for (int i = 0; i <= 3 - a; i++) res[8*i +: 8] = mb[a+i];
         end
         default: ;
      endcase
   endfunction

   task automatic drive_load(input logic [2:0] kind, input int a, input logic sgn,
                             input logic bo, input logic [31:0] mem,
                             input logic [31:0] old, input string tag);
      logic ok, mis;
      logic [31:0] res;
      @(negedge clk);
      ld_valid = 1'b1; ld_kind = kind; ld_ofs = 2'(a); ld_signed = sgn;
      big_end = bo; ld_mem = mem; ld_old = old;
      ld_model(kind, a, sgn, bo, mem, old, ok, mis, res);
      if (!ok) res = exp_hold;
      exp_hold = res;
      exp_q.push_back({ok, mis, res});
      tag_q.push_back(tag);
   endtask

   task automatic drive_idle(input string tag);
      @(negedge clk);
      ld_valid = 1'b0;
      ld_mem   = 32'hFFFF_FFFF;
      exp_q.push_back({1'b0, 1'b0, exp_hold});
      tag_q.push_back(tag);
   endtask

   // monitor: compares one item after each capturing edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [33:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " wen"},  {31'd0, ld_wen},      {31'd0, e[33]});
            check({t, " mis"},  {31'd0, ld_misalign}, {31'd0, e[32]});
            check({t, " data"}, ld_data,              e[31:0]);
         end
      end
   end

   task automatic do_store(input logic [2:0] kind, input int a, input logic bo,
                           input logic [31:0] d, input string tag,
                           output logic [31:0] wd, output logic [3:0] en);
      logic [7:0]  sb[4];
      logic [3:0]  eb;
      logic [31:0] ed, cm;
      logic        em;
      for (int i = 0; i < 4; i++) sb[i] = 8'h00;
      eb = 4'b0; em = 1'b0; ed = 32'h0;
      case (kind)
         3'd0: begin eb = 4'b1 << a; ed = {4{d[7:0]}}; end
         3'd1: begin
            ed = bo ? {2{d[7:0], d[15:8]}} : {2{d[15:0]}};
            if (a % 2 == 1) em = 1'b1; else eb = 4'b11 << a;
         end
         3'd2: begin
            ed = bo ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
            if (a != 0) em = 1'b1; else eb = 4'hF;
         end
         3'd3: begin
            if (bo) for (int j = 0; j <= 3 - a; j++) begin sb[a+j] = d[8*(3-j) +: 8]; eb[a+j] = 1'b1; end
            else    for (int j = 0; j <= a; j++)     begin sb[a-j] = d[8*(3-j) +: 8]; eb[a-j] = 1'b1; end
            ed = {sb[3], sb[2], sb[1], sb[0]};
         end
         3'd4: begin
            if (bo) for (int i = 0; i <= a; i++)     begin sb[a-i] = d[8*i +: 8]; eb[a-i] = 1'b1; end
            else    for (int i = 0; i <= 3 - a; i++) begin sb[a+i] = d[8*i +: 8]; eb[a+i] = 1'b1; end
            ed = {sb[3], sb[2], sb[1], sb[0]};
         end
         default: ;
      endcase
      if (kind <= 3'd1) cm = em ? 32'h0 : 32'hFFFF_FFFF;
      else              cm = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
      @(negedge clk);
      st_valid = 1'b1; st_kind = kind; st_ofs = 2'(a); big_end = bo; st_src = d;
      #1;
      check({tag, " be"},   {28'd0, st_be},            {28'd0, eb});
      check({tag, " mis"},  {31'd0, st_misalign},      {31'd0, em});
      check({tag, " data"}, st_wdata & cm,             ed & cm);
      wd = st_wdata;
      en = st_be;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] wd;
      logic [3:0]  en;
      logic [7:0]  m8[8];
      rst_n = 1'b0; big_end = 1'b0;
      ld_valid = 1'b0; ld_kind = 3'd0; ld_ofs = 2'd0; ld_signed = 1'b0;
      ld_mem = 32'h0; ld_old = 32'h0;
      st_valid = 1'b0; st_kind = 3'd0; st_ofs = 2'd0; st_src = 32'h0;
      exp_hold = 32'h0;
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7 reset wen",  {31'd0, ld_wen},      32'd0);
      check("R7 reset mis",  {31'd0, ld_misalign}, 32'd0);
      check("R7 reset data", ld_data,              32'd0);
      check("R11 idle store be", {28'd0, st_be},   32'd0);
      rst_n = 1'b1;

      // R1: every byte lane, both orders, both extensions
      for (int bo = 0; bo < 2; bo++)
         for (int s = 0; s < 2; s++)
            for (int a = 0; a < 4; a++)
               drive_load(3'd0, a, s[0], bo[0], 32'hC37E_8124, 32'h1111_1111, "R1 byte load");
      // R2: halfwords, both orders
      for (int bo = 0; bo < 2; bo++)
         for (int s = 0; s < 2; s++) begin
            drive_load(3'd1, 0, s[0], bo[0], 32'h13A5_F08C, 32'h0, "R2 half load");
            drive_load(3'd1, 2, s[0], bo[0], 32'h13A5_F08C, 32'h0, "R2 half load");
         end
      // R3: words
      drive_load(3'd2, 0, 1'b0, 1'b0, 32'h0102_0304, 32'h0, "R3 word load LE");
      drive_load(3'd2, 0, 1'b1, 1'b1, 32'h0102_0304, 32'h0, "R3 word load BE");
      // R6: misaligned loads keep the previous result
      drive_load(3'd1, 1, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0, "R6 half odd");
      drive_load(3'd1, 3, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0, "R6 half odd");
      drive_load(3'd2, 2, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0, "R6 word unaligned");
      drive_idle("R7 idle");
      drive_idle("R7 idle");
      // R4 and R5: partial merges at every offset
      for (int bo = 0; bo < 2; bo++)
         for (int a = 0; a < 4; a++) begin
            drive_load(3'd3, a, 1'b1, bo[0], 32'hA1B2_C3D4, 32'h5566_7788, "R4 left load");
            drive_load(3'd4, a, 1'b1, bo[0], 32'hA1B2_C3D4, 32'h5566_7788, "R5 right load");
         end
      // R12: pairs assemble one unaligned word
      drive_load(3'd4, 1, 1'b0, 1'b0, 32'h4433_2211, 32'hAA00_0000, "R12 LE pair first");
      drive_load(3'd3, 0, 1'b0, 1'b0, 32'h8877_6655, 32'hAA44_3322, "R12 LE pair gives 55443322");
      drive_load(3'd3, 2, 1'b0, 1'b1, 32'h4433_2211, 32'h0000_00BB, "R12 BE pair first");
      drive_load(3'd4, 1, 1'b0, 1'b1, 32'h8877_6655, 32'h3344_00BB, "R12 BE pair gives 33445566");
      drive_load(3'd6, 0, 1'b0, 1'b0, 32'h1234_5678, 32'h0, "R7 unused kind");
      drive_idle("R7 idle");
      drive_idle("R7 drain");
      @(negedge clk);

      // stores
      for (int bo = 0; bo < 2; bo++)
         for (int a = 0; a < 4; a++) begin
            do_store(3'd0, a, bo[0], 32'h1234_56A7, "R8 byte store", wd, en);
            do_store(3'd1, a, bo[0], 32'h1234_56A7, "R8/R11 half store", wd, en);
            do_store(3'd2, a, bo[0], 32'hCAFE_F00D, "R9/R11 word store", wd, en);
            do_store(3'd3, a, bo[0], 32'hA1B2_C3D4, "R10 left store", wd, en);
            do_store(3'd4, a, bo[0], 32'hA1B2_C3D4, "R10 right store", wd, en);
         end

      // R12: store pairs written into a byte memory
      for (int i = 0; i < 8; i++) m8[i] = 8'h00;
      do_store(3'd3, 2, 1'b1, 32'hA1B2_C3D4, "R12 BE store pair", wd, en);
      for (int i = 0; i < 4; i++) if (en[i]) m8[i] = wd[8*i +: 8];
      do_store(3'd4, 1, 1'b1, 32'hA1B2_C3D4, "R12 BE store pair", wd, en);
      for (int i = 0; i < 4; i++) if (en[i]) m8[4+i] = wd[8*i +: 8];
      check("R12 BE stored word", {m8[2], m8[3], m8[4], m8[5]}, 32'hA1B2_C3D4);
      check("R12 BE neighbours",  {m8[0], m8[1], m8[6], m8[7]}, 32'h0);
      for (int i = 0; i < 8; i++) m8[i] = 8'h00;
      do_store(3'd4, 3, 1'b0, 32'hA1B2_C3D4, "R12 LE store pair", wd, en);
      for (int i = 0; i < 4; i++) if (en[i]) m8[i] = wd[8*i +: 8];
      do_store(3'd3, 2, 1'b0, 32'hA1B2_C3D4, "R12 LE store pair", wd, en);
      for (int i = 0; i < 4; i++) if (en[i]) m8[4+i] = wd[8*i +: 8];
      check("R12 LE stored word", {m8[6], m8[5], m8[4], m8[3]}, 32'hA1B2_C3D4);
      check("R12 LE neighbours",  {m8[0], m8[1], m8[2], m8[7]}, 32'h0);

      // R11: invalid store enables nothing
      @(negedge clk);
      st_valid = 1'b0; st_kind = 3'd2; st_ofs = 2'd0;
      #1;
      check("R11 invalid store be",  {28'd0, st_be},       32'd0);
      check("R11 invalid store mis", {31'd0, st_misalign}, 32'd0);

      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule